// File: doc/BRIEF.md
# Vectored Interrupt Controller with Per-Source Trigger Selection

This block gathers a wide set of peripheral interrupt lines, 24 groups of 8 (192 sources) by default. Every line passes through a two-stage synchronizer. Each source has its own sense: it can trigger on a level (high or low) or on an edge (rising or falling). A detected event latches a pending status bit. The status bit latches even while the source is masked.

Enable bits mask the pending sources. The single CPU request output is high whenever any pending source is also enabled. A registered vector register names the winning source: the highest-numbered source that is both pending and enabled, plus a fixed offset. Software services a request in three steps: read the vector, subtract the offset, then clear that source's status bit by writing a one to it.

All configuration and status travel over a simple byte-wide bus. Writes take effect on the clock edge. Reads are combinational from the stored state.

Top module: `irq_vector_ctrl`

## Requirements
- R1: After reset, every status, enable, mode and polarity bit is 0, the vector register reads 0x10 and `cpu_irq` is low.
- R2: Address decoding works as follows. `bus_addr[7]`=1 selects the vector register, which is read-only: writes to it are ignored. Otherwise `bus_addr[6:5]` selects the register kind (0 status, 1 enable, 2 mode, 3 polarity) and `bus_addr[4:0]` selects the group. Source n lives in group n/8 at bit n%8. Groups 24 to 31 read as 0 and ignore writes.
- R3: With its mode bit at 1 (edge), a source with polarity 0 latches status on a rising transition and one with polarity 1 on a falling transition. The opposite transition latches nothing. The latched bit stays set after the line returns to its idle level.
- R4: With its mode bit at 0 (level), a source's status is set on every cycle its active level is present (high for polarity 0, low for polarity 1). A clear written while the level is present has no lasting effect. Once the level is gone, the bit stays set until it is cleared.
- R5: Writing a byte to a status register clears exactly the bits written as 1. Bits written as 0 are unchanged.
- R6: A masked source still latches status. `cpu_irq` is high exactly when some source has both its status and enable bits set, and it rises in the cycle that the enable write lands.
- R7: The vector register holds the highest-numbered source that is both pending and enabled, plus 0x10. It holds 0x10 when no such source exists. Source 0 also reads 0x10, and only `cpu_irq` tells it apart from the idle case.
- R8: A line change is latched into status on the third rising clock edge after it is applied. `cpu_irq` follows in the same cycle. The vector register follows one edge later.
- R9: Enable, mode and polarity registers store the byte written and read it back unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| irq_lines | input | 192 | Raw peripheral interrupt lines, source n on bit n |
| bus_sel | input | 1 | Register access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Register address (vector / kind / group) |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational |
| cpu_irq | output | 1 | Interrupt request to the CPU |

## Verification
The embedded assertions check on every cycle that each source's status bit follows its detection and clear events. They also check that enables move only on an enable write, that the vector register tracks the priority encoder's winner one edge later, and that the request is never raised without a pending winner. The following are shown only by the bench's directed scenarios: the meaning of each polarity and mode combination, the three-edge latency, the priority order across groups and within a group, and the decoding of the register map, including the unused groups and the read-only vector.

// File: rtl/ivc_pkg.sv
package ivc_pkg;

  typedef enum logic [1:0] {
    KIND_STATUS = 2'd0,
    KIND_ENABLE = 2'd1,
    KIND_MODE   = 2'd2,
    KIND_POLAR  = 2'd3
  } reg_kind_e;

  // Vector code: winner index plus offset, or the bare offset when idle.
  function automatic int unsigned vector_code(input int unsigned idx,
                                              input bit valid,
                                              input int unsigned off);
    return valid ? (idx + off) : off;
  endfunction

  // Flat source index from group and bit position.
  function automatic int unsigned flat_index(input int unsigned grp,
                                             input int unsigned pos,
                                             input int unsigned width);
    return grp * width + pos;
  endfunction

endpackage

// File: rtl/ivc_sync.sv
module ivc_sync #(
  parameter int W      = 192,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);

  logic [W-1:0] stage_q [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < STAGES; s++) stage_q[s] <= '0;
    end else begin
      stage_q[0] <= din;
      for (int s = 1; s < STAGES; s++) stage_q[s] <= stage_q[s-1];
    end
  end

  assign dout = stage_q[STAGES-1];

endmodule

// File: rtl/ivc_detect.sv
module ivc_detect #(
  parameter int N = 192
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] line_sync,
  input  logic [N-1:0] mode_edge,
  input  logic [N-1:0] polar_low,
  input  logic [N-1:0] clr,
  output logic [N-1:0] status,
  output logic [N-1:0] hit
);

  logic [N-1:0] prev_q;
  logic [N-1:0] status_q;
  logic [N-1:0] level_active;
  logic [N-1:0] rise_ev;
  logic [N-1:0] fall_ev;
  logic [N-1:0] edge_ev;

  always_comb begin
    level_active = line_sync ^ polar_low;
    rise_ev      = line_sync & ~prev_q;
    fall_ev      = ~line_sync & prev_q;
    edge_ev      = (rise_ev & ~polar_low) | (fall_ev & polar_low);
    hit          = (edge_ev & mode_edge) | (level_active & ~mode_edge);
  end

  // A new event wins over a clear written in the same cycle.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q   <= '0;
      status_q <= '0;
    end else begin
      prev_q   <= line_sync;
      status_q <= hit | (status_q & ~clr);
    end
  end

  assign status = status_q;

  for (genvar i = 0; i < N; i++) begin : g_chk
    // R3 / R4: a detected event is latched on the next edge
    a_r3_event_latches: assert property (@(posedge clk) disable iff (!rst_n)
      hit[i] |=> status_q[i]);
    // R5: a clear with no competing event empties the bit
    a_r5_clear_empties: assert property (@(posedge clk) disable iff (!rst_n)
      (clr[i] && !hit[i]) |=> !status_q[i]);
    // R3: no status appears without an event
    a_r3_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
      (!status_q[i] && !hit[i]) |=> !status_q[i]);
  end

endmodule

// File: rtl/ivc_prio.sv
module ivc_prio #(
  parameter int NUM_GROUPS = 24,
  parameter int GROUP_W    = 8,
  parameter int IDX_W      = 8
) (
  input  logic [NUM_GROUPS*GROUP_W-1:0] pend,
  output logic                          win_valid,
  output logic [IDX_W-1:0]              win_idx
);

  localparam int N       = NUM_GROUPS * GROUP_W;
  localparam int GRP_IW  = (NUM_GROUPS > 1) ? $clog2(NUM_GROUPS) : 1;
  localparam int BIT_IW  = (GROUP_W > 1) ? $clog2(GROUP_W) : 1;

  logic [NUM_GROUPS-1:0] grp_any;
  logic [GROUP_W-1:0]    grp_bits [NUM_GROUPS];
  logic [GRP_IW-1:0]     grp_win;
  logic [BIT_IW-1:0]     bit_win;

  for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
    assign grp_bits[g] = pend[g*GROUP_W +: GROUP_W];
    assign grp_any[g]  = |pend[g*GROUP_W +: GROUP_W];
  end

  function automatic logic [GRP_IW-1:0] top_group(input logic [NUM_GROUPS-1:0] v);
    logic [GRP_IW-1:0] r;
    r = '0;
    for (int k = 0; k < NUM_GROUPS; k++) if (v[k]) r = GRP_IW'(k);
    return r;
  endfunction

  function automatic logic [BIT_IW-1:0] top_bit(input logic [GROUP_W-1:0] v);
    logic [BIT_IW-1:0] r;
    r = '0;
    for (int k = 0; k < GROUP_W; k++) if (v[k]) r = BIT_IW'(k);
    return r;
  endfunction

  always_comb begin
    win_valid = |grp_any;
    grp_win   = top_group(grp_any);
    bit_win   = top_bit(grp_bits[grp_win]);
    win_idx   = IDX_W'(ivc_pkg::flat_index(int'(grp_win), int'(bit_win), GROUP_W));
  end

  // R7: the winner is pending and nothing above it is pending
  always_comb begin
    if (win_valid) begin
      a_r7_winner_pending: assert (pend[win_idx]);
      a_r7_none_above: assert ((pend >> win_idx) == N'(1));
    end
  end

endmodule

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl #(
  parameter int NUM_GROUPS = 24,
  parameter int GROUP_W    = 8,
  parameter int SYNC_STAGES = 2,
  parameter int VEC_OFFSET = 16
) (
  input  logic                                 clk,
  input  logic                                 rst_n,
  input  logic [NUM_GROUPS*GROUP_W-1:0]        irq_lines,
  input  logic                                 bus_sel,
  input  logic                                 bus_we,
  input  logic [$clog2(NUM_GROUPS)+2:0]        bus_addr,
  input  logic [GROUP_W-1:0]                   bus_wdata,
  output logic [GROUP_W-1:0]                   bus_rdata,
  output logic                                 cpu_irq
);

  import ivc_pkg::*;

  localparam int N      = NUM_GROUPS * GROUP_W;
  localparam int GRP_AW = $clog2(NUM_GROUPS);
  localparam int ADDR_W = GRP_AW + 3;
  localparam int IDX_W  = $clog2(N + VEC_OFFSET);

  logic [N-1:0] line_sync;
  logic [N-1:0] enable_q, mode_q, polar_q;
  logic [N-1:0] status, hit, clr, pending;
  logic         win_valid;
  logic [IDX_W-1:0] win_idx;
  logic [GROUP_W-1:0] vec_q;

  // Bus decode, brought out as named events.
  logic        vec_sel;
  logic [GRP_AW-1:0] grp_sel;
  reg_kind_e   kind;
  logic        grp_ok;
  logic        wr_any;

  assign vec_sel = bus_addr[ADDR_W-1];
  assign kind    = reg_kind_e'(bus_addr[GRP_AW+1:GRP_AW]);
  assign grp_sel = bus_addr[GRP_AW-1:0];
  assign grp_ok  = int'(grp_sel) < NUM_GROUPS;
  assign wr_any  = bus_sel && bus_we && !vec_sel && grp_ok;

  ivc_sync #(.W(N), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .din(irq_lines), .dout(line_sync)
  );

  ivc_detect #(.N(N)) u_detect (
    .clk(clk), .rst_n(rst_n), .line_sync(line_sync),
    .mode_edge(mode_q), .polar_low(polar_q), .clr(clr),
    .status(status), .hit(hit)
  );

  // Per-group configuration storage and clear strobes.
  for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_cfg
    logic grp_hit;
    assign grp_hit = wr_any && (int'(grp_sel) == g);
    assign clr[g*GROUP_W +: GROUP_W] =
      (grp_hit && kind == KIND_STATUS) ? bus_wdata : '0;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        enable_q[g*GROUP_W +: GROUP_W] <= '0;
        mode_q[g*GROUP_W +: GROUP_W]   <= '0;
        polar_q[g*GROUP_W +: GROUP_W]  <= '0;
      end else if (grp_hit) begin
        case (kind)
          KIND_ENABLE: enable_q[g*GROUP_W +: GROUP_W] <= bus_wdata;
          KIND_MODE:   mode_q[g*GROUP_W +: GROUP_W]   <= bus_wdata;
          KIND_POLAR:  polar_q[g*GROUP_W +: GROUP_W]  <= bus_wdata;
          default: ;
        endcase
      end
    end
  end

  assign pending = status & enable_q;
  assign cpu_irq = |pending;

  ivc_prio #(.NUM_GROUPS(NUM_GROUPS), .GROUP_W(GROUP_W), .IDX_W(IDX_W)) u_prio (
    .pend(pending), .win_valid(win_valid), .win_idx(win_idx)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vec_q <= GROUP_W'(VEC_OFFSET);
    else        vec_q <= GROUP_W'(vector_code(int'(win_idx), win_valid, VEC_OFFSET));
  end

  // Combinational read path.
  logic [GROUP_W-1:0] rd_slice [NUM_GROUPS];
  for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_rd
    always_comb begin
      case (kind)
        KIND_STATUS: rd_slice[g] = status[g*GROUP_W +: GROUP_W];
        KIND_ENABLE: rd_slice[g] = enable_q[g*GROUP_W +: GROUP_W];
        KIND_MODE:   rd_slice[g] = mode_q[g*GROUP_W +: GROUP_W];
        default:     rd_slice[g] = polar_q[g*GROUP_W +: GROUP_W];
      endcase
    end
  end

  always_comb begin
    if (vec_sel)     bus_rdata = vec_q;
    else if (grp_ok) bus_rdata = rd_slice[grp_sel];
    else             bus_rdata = '0;
  end

  // R9: enables move only on an enable write
  a_r9_enable_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_any && kind == KIND_ENABLE) |=> $stable(enable_q));
  // R7: idle encoder gives the bare offset one edge later
  a_r7_idle_vector: assert property (@(posedge clk) disable iff (!rst_n)
    !win_valid |=> (vec_q == GROUP_W'(VEC_OFFSET)));
  // R7: winner reaches the vector register one edge later
  a_r7_winner_vector: assert property (@(posedge clk) disable iff (!rst_n)
    win_valid |=> (vec_q == GROUP_W'($past(win_idx)) + GROUP_W'(VEC_OFFSET)));
  // R6: request only with a pending winner
  a_r6_irq_cause: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_irq |-> win_valid);

endmodule

// File: tb/irq_vector_ctrl_test.sv
`timescale 1ns/1ps
module irq_vector_ctrl_test;

  localparam int NG = 24;
  localparam int GW = 8;
  localparam logic [1:0] K_ST = 2'd0, K_EN = 2'd1, K_MD = 2'd2, K_PL = 2'd3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NG*GW-1:0] lines = '0;
  logic bus_sel = 1'b0, bus_we = 1'b0;
  logic [7:0] bus_addr = '0, bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic cpu_irq;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  irq_vector_ctrl uut (
    .clk(clk), .rst_n(rst_n), .irq_lines(lines), .bus_sel(bus_sel),
    .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .cpu_irq(cpu_irq)
  );

  always #2.5 clk = ~clk;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic rd(input logic [1:0] k, input int g, output logic [7:0] d);
    bus_addr = {1'b0, k, 5'(g)};
    bus_sel = 1'b1; bus_we = 1'b0;
    #1 d = bus_rdata;
    bus_sel = 1'b0;
  endtask

  task automatic rd_vec(output logic [7:0] d);
    bus_addr = 8'h80; bus_sel = 1'b1; bus_we = 1'b0;
    #1 d = bus_rdata;
    bus_sel = 1'b0;
  endtask

  task automatic wr_raw(input logic [7:0] a, input logic [7:0] d);
    bus_addr = a; bus_wdata = d; bus_sel = 1'b1; bus_we = 1'b1;
    @(negedge clk);
    bus_sel = 1'b0; bus_we = 1'b0;
  endtask

  task automatic wr(input logic [1:0] k, input int g, input logic [7:0] d);
    wr_raw({1'b0, k, 5'(g)}, d);
  endtask

  task automatic set_bit(input logic [1:0] k, input int src, input bit v);
    logic [7:0] d;
    rd(k, src / GW, d);
    d[src % GW] = v;
    wr(k, src / GW, d);
  endtask

  task automatic t_reset;
    logic [7:0] d;
    int nz = 0;
    for (int g = 0; g < NG; g++) begin
      rd(K_EN, g, d); if (d != 0) nz++;
      rd(K_ST, g, d); if (d != 0) nz++;
      rd(K_MD, g, d); if (d != 0) nz++;
      rd(K_PL, g, d); if (d != 0) nz++;
    end
    chk("R1 registers clear after reset", nz, 0);
    rd_vec(d);
    chk("R1 vector idle after reset", d, 8'h10);
    chk("R1 cpu_irq low after reset", cpu_irq, 0);
  endtask

  // R8: source 9 (group 1 bit 1) rising edge, enabled beforehand
  task automatic t_latency;
    logic [7:0] d;
    set_bit(K_MD, 9, 1'b1);
    set_bit(K_EN, 9, 1'b1);
    lines[9] = 1'b1;
    idle(2);
    chk("R8 no request after two edges", cpu_irq, 0);
    idle(1);
    chk("R8 request on third edge", cpu_irq, 1);
    rd_vec(d);
    chk("R8 vector lags request by one edge", d, 8'h10);
    idle(1);
    rd_vec(d);
    chk("R8 vector after fourth edge", d, 9 + 16);
    lines[9] = 1'b0;
    set_bit(K_EN, 9, 1'b0);
    wr(K_ST, 1, 8'h02);
    set_bit(K_MD, 9, 1'b0);
    idle(4);
  endtask

  // R3 R5 R6 R7: source 5 rising edge while masked
  task automatic t_edge_rise;
    logic [7:0] d;
    set_bit(K_MD, 5, 1'b1);
    lines[5] = 1'b1; idle(5);
    rd(K_ST, 0, d);
    chk("R3 rising edge latched", d, 8'h20);
    chk("R6 masked source raises no request", cpu_irq, 0);
    lines[5] = 1'b0; idle(5);
    rd(K_ST, 0, d);
    chk("R3 edge status held after line drops", d, 8'h20);
    set_bit(K_EN, 5, 1'b1);
    chk("R6 request on enable write", cpu_irq, 1);
    idle(1);
    rd_vec(d);
    chk("R7 vector for source 5", d, 8'h15);
    wr(K_ST, 0, 8'hDF);
    rd(K_ST, 0, d);
    chk("R5 zero bits leave status", d, 8'h20);
    wr(K_ST, 0, 8'h20);
    rd(K_ST, 0, d);
    chk("R5 one bit clears status", d, 8'h00);
    chk("R6 request drops after clear", cpu_irq, 0);
    idle(1);
    rd_vec(d);
    chk("R7 vector idle after clear", d, 8'h10);
    set_bit(K_EN, 5, 1'b0);
    set_bit(K_MD, 5, 1'b0);
  endtask

  // R3: source 100 (group 12 bit 4) falling edge
  task automatic t_edge_fall;
    logic [7:0] d;
    set_bit(K_MD, 100, 1'b1);
    set_bit(K_PL, 100, 1'b1);
    lines[100] = 1'b1; idle(5);
    rd(K_ST, 12, d);
    chk("R3 rising ignored with polarity 1", d, 8'h00);
    lines[100] = 1'b0; idle(5);
    rd(K_ST, 12, d);
    chk("R3 falling edge latched", d, 8'h10);
    set_bit(K_EN, 100, 1'b1);
    idle(2);
    rd_vec(d);
    chk("R7 vector for source 100", d, 100 + 16);
    set_bit(K_EN, 100, 1'b0);
    set_bit(K_PL, 100, 1'b0);
    set_bit(K_MD, 100, 1'b0);
    wr(K_ST, 12, 8'h10);
    idle(2);
  endtask

  // R4: source 30 (group 3 bit 6) level high
  task automatic t_level_high;
    logic [7:0] d;
    lines[30] = 1'b1; idle(5);
    rd(K_ST, 3, d);
    chk("R4 high level latched", d, 8'h40);
    wr(K_ST, 3, 8'h40);
    idle(1);
    rd(K_ST, 3, d);
    chk("R4 clear ignored while level present", d, 8'h40);
    lines[30] = 1'b0; idle(5);
    rd(K_ST, 3, d);
    chk("R4 status kept after level gone", d, 8'h40);
    wr(K_ST, 3, 8'h40);
    rd(K_ST, 3, d);
    chk("R4 clear works once level gone", d, 8'h00);
  endtask

  // R4 R2: source 191 (group 23 bit 7) level low, unused group 24
  task automatic t_level_low;
    logic [7:0] d;
    set_bit(K_PL, 191, 1'b1);
    idle(5);
    rd(K_ST, 23, d);
    chk("R4 low level latched", d, 8'h80);
    set_bit(K_EN, 191, 1'b1);
    idle(2);
    rd_vec(d);
    chk("R7 vector for source 191", d, 191 + 16);
    chk("R6 request for source 191", cpu_irq, 1);
    set_bit(K_EN, 191, 1'b0);
    set_bit(K_PL, 191, 1'b0);
    wr(K_ST, 23, 8'h80);
    rd(K_ST, 23, d);
    chk("R5 clear of source 191", d, 8'h00);
    wr(K_EN, 24, 8'hFF);
    rd(K_EN, 24, d);
    chk("R2 unused group reads zero", d, 8'h00);
    chk("R2 unused group write raises nothing", cpu_irq, 0);
  endtask

  // R7: priority across and within groups
  task automatic t_priority;
    logic [7:0] d;
    set_bit(K_EN, 3, 1'b1);
    set_bit(K_EN, 40, 1'b1);
    set_bit(K_EN, 45, 1'b1);
    set_bit(K_EN, 150, 1'b1);
    lines[3] = 1'b1; lines[40] = 1'b1; lines[45] = 1'b1; lines[150] = 1'b1;
    idle(5);
    rd_vec(d);
    chk("R7 highest source 150 wins", d, 150 + 16);
    set_bit(K_EN, 150, 1'b0);
    idle(1);
    rd_vec(d);
    chk("R7 higher bit in group 5 wins", d, 45 + 16);
    set_bit(K_EN, 45, 1'b0);
    idle(1);
    rd_vec(d);
    chk("R7 source 40 over source 3", d, 40 + 16);
    lines[3] = 1'b0; lines[40] = 1'b0; lines[45] = 1'b0; lines[150] = 1'b0;
    idle(4);
    wr(K_EN, 0, 8'h00); wr(K_EN, 5, 8'h00);
    wr(K_ST, 0, 8'hFF); wr(K_ST, 5, 8'hFF); wr(K_ST, 18, 8'hFF);
    idle(1);
    rd_vec(d);
    chk("R7 idle after priority cleanup", d, 8'h10);
  endtask

  // R9 R2: readback and read-only vector
  task automatic t_regs;
    logic [7:0] d;
    wr(K_MD, 7, 8'hA5);
    rd(K_MD, 7, d);
    chk("R9 mode readback", d, 8'hA5);
    wr(K_EN, 7, 8'h00);
    wr(K_PL, 7, 8'h3C);
    rd(K_PL, 7, d);
    chk("R9 polarity readback", d, 8'h3C);
    wr(K_EN, 11, 8'h5A);
    rd(K_EN, 11, d);
    chk("R9 enable readback", d, 8'h5A);
    wr(K_EN, 11, 8'h00);
    wr(K_PL, 7, 8'h00);
    wr(K_MD, 7, 8'h00);
    wr(K_ST, 7, 8'hFF);
    wr_raw(8'h80, 8'h55);
    idle(1);
    rd_vec(d);
    chk("R2 vector ignores writes", d, 8'h10);
  endtask

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(1);
    t_reset();
    t_latency();
    t_edge_rise();
    t_edge_fall();
    t_level_high();
    t_level_low();
    t_priority();
    t_regs();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #500000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule